// File: doc/BRIEF.md
# GPIO Port Register Bank with Masked-Write Aliases

This block is the register file for one bank of 32 general-purpose pins. The 32 pins are grouped into four ports of eight. For each port it keeps five control registers: pin enable, drive enable, drive value, interrupt enable and interrupt type. It also has a status register, a clear register that can only be written, and a read-only view of the pad inputs. Edge and level detection sits outside the block. The detector reports events through per-pin status set pulses, and this block only latches them.

Every register that can be written has two addresses: a plain one and a masked alias. In a masked alias word, bits 15:8 choose which pins of the port change and bits 7:0 give their new values. Software can therefore change one pin with a single write and no read-modify-write, even when other agents touch neighbouring pins. A pad drives only when its pin enable and its drive enable are both set.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every register, `busRdData`, `padOut` and `padOe` are zero, so all pins start undriven with interrupts disabled.
- R2: A write to base + func + port*4 replaces that port's register: func 0x00 pin enable, 0x10 drive enable, 0x20 drive value, 0x40 status, 0x50 interrupt enable (bits 7:0), and 0x60 interrupt type (bits 23:0). A read issued in one cycle returns the register in `busRdData` on the next cycle, zero-extended. In all other cycles `busRdData` is zero.
- R3: A write to the masked alias (plain address + UPPER_OFFSET, 0x800 by default) updates only the pins whose bit in 15:8 is 1, each to its bit in 7:0. All other pins keep their state. Reads of an alias return the plain register.
- R4: A masked write to the interrupt-type alias changes only bits 7:0 of that port's 24-bit type register. Bits 23:8 keep their values.
- R5: A read at func 0x30 returns the eight `padIn` bits of that port. Writes to 0x30 and to 0x30 + UPPER_OFFSET change nothing, and a read of 0x30 + UPPER_OFFSET returns zero.
- R6: A write to func 0x70 clears each status bit whose data bit is 1 and leaves the others alone. Reads of 0x70 return zero. The alias at 0x70 + UPPER_OFFSET ignores writes.
- R7: A `statusSet` pulse sets the matching status bit. When a set and a clear (or any status write) hit the same pin in the same cycle, the set wins.
- R8: `padOut` equals the drive-value bits. A bit of `padOe` is 1 only when both the pin-enable and drive-enable bits are 1.
- R9: Addresses outside the bank's two windows (for example, another bank at base + BANK_STRIDE) have no effect on writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read strobe; data follows one cycle later |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| padIn | input | 32 | Pad input levels |
| padOut | output | 32 | Pad output values |
| padOe | output | 32 | Pad drive enables |
| statusSet | input | 32 | Per-pin status set pulses from the detector |

## Verification
The assertions watch several properties on every cycle. Pins outside the mask of a masked drive-value write do not move. A set pulse is present in status one cycle later whatever the bus did. A read of the clear register returns zero. A pad drive enable rises only after a bus write. The register is also zero when reset is released. Other properties depend on cross-register state and can only be shown by the bench scenarios. These are the preservation of the upper type planes, read-back of each function, the ignored writes to the input register and to foreign addresses, and the contents that status keeps after a clear. The bench compares all of these against a model that tracks every register.

// File: rtl/gpio_port_bank_pkg.sv
package gpio_port_bank_pkg;

  localparam int PORT_PINS  = 8;
  localparam int PORT_IDX_W = 2;
  localparam int TYPE_W     = 3 * PORT_PINS;

  typedef enum logic [2:0] {
    FN_CFG = 3'd0,
    FN_OE  = 3'd1,
    FN_OUT = 3'd2,
    FN_IN  = 3'd3,
    FN_STA = 3'd4,
    FN_EN  = 3'd5,
    FN_TYP = 3'd6,
    FN_CLR = 3'd7
  } funcSel_e;

  typedef struct packed {
    logic                  wrNorm;
    logic                  wrMask;
    logic                  wrClr;
    logic                  rdEn;
    funcSel_e              func;
    logic [PORT_IDX_W-1:0] port;
  } strobe_t;

  // Next value of an 8-bit pin group under a plain or masked write.
  function automatic logic [PORT_PINS-1:0] byteNext(
      input logic [PORT_PINS-1:0]   cur,
      input logic                   plain,
      input logic                   masked,
      input logic [2*PORT_PINS-1:0] data);
    logic [PORT_PINS-1:0] sel;
    sel = data[2*PORT_PINS-1:PORT_PINS];
    if (plain)       byteNext = data[PORT_PINS-1:0];
    else if (masked) byteNext = (cur & ~sel) | (data[PORT_PINS-1:0] & sel);
    else             byteNext = cur;
  endfunction

endpackage

// File: rtl/gpio_port_bank_ctrl.sv
module gpio_port_bank_ctrl
  import gpio_port_bank_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PORTS        = 4,
  parameter int BANK_SEL     = 0,
  parameter int BANK_STRIDE  = 'h80,
  parameter int UPPER_OFFSET = 'h800
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);

  localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(BANK_SEL * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] UPPER = ADDR_W'(UPPER_OFFSET);
  localparam logic [ADDR_W-1:0] WIN   = ADDR_W'(8 * 16);

  logic [ADDR_W-1:0] offN, offM;
  logic              inN, inM, portOk, hasAlias;
  logic [2:0]        fnBits;
  logic [1:0]        portBits;
  funcSel_e          fn;

  always_comb begin
    offN     = busAddr - BASE;
    offM     = busAddr - BASE - UPPER;
    inN      = offN < WIN;
    inM      = offM < WIN;
    fnBits   = inN ? offN[6:4] : offM[6:4];
    portBits = inN ? offN[3:2] : offM[3:2];
    fn       = funcSel_e'(fnBits);
    portOk   = 32'(portBits) < PORTS;
    hasAlias = (fn != FN_IN) && (fn != FN_CLR);

    strb.func   = fn;
    strb.port   = portBits;
    strb.wrNorm = busWrEn && inN && portOk && hasAlias;
    strb.wrMask = busWrEn && inM && portOk && hasAlias;
    strb.wrClr  = busWrEn && inN && portOk && (fn == FN_CLR);
    strb.rdEn   = busRdEn && portOk && (inN || (inM && hasAlias));
  end

endmodule

// File: rtl/gpio_port_bank_dp.sv
module gpio_port_bank_dp
  import gpio_port_bank_pkg::*;
#(
  parameter int PORTS = 4,
  localparam int PINS = PORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [31:0]       wrData,
  input  logic [PINS-1:0]   padIn,
  input  logic [PINS-1:0]   statusSet,
  output logic [31:0]       rdData,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   staFlat
);

  logic [PINS-1:0]        cfgFlat, oeFlat, outFlat, enFlat;
  logic [PORTS*TYPE_W-1:0] typFlat;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [PORT_PINS-1:0] cfgR, oeR, outR, enR, staR, staNext;
    logic [TYPE_W-1:0]    typR;
    logic                 selP, nrm, msk;

    assign selP = strb.port == PORT_IDX_W'(p);
    assign nrm  = strb.wrNorm && selP;
    assign msk  = strb.wrMask && selP;

    always_comb begin
      staNext = byteNext(staR, nrm && strb.func == FN_STA,
                         msk && strb.func == FN_STA, wrData[15:0]);
      if (strb.wrClr && selP) staNext = staNext & ~wrData[PORT_PINS-1:0];
      staNext = staNext | statusSet[p*PORT_PINS +: PORT_PINS];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgR <= '0;
        oeR  <= '0;
        outR <= '0;
        enR  <= '0;
        staR <= '0;
        typR <= '0;
      end else begin
        staR <= staNext;
        unique case (strb.func)
          FN_CFG: cfgR <= byteNext(cfgR, nrm, msk, wrData[15:0]);
          FN_OE:  oeR  <= byteNext(oeR,  nrm, msk, wrData[15:0]);
          FN_OUT: outR <= byteNext(outR, nrm, msk, wrData[15:0]);
          FN_EN:  enR  <= byteNext(enR,  nrm, msk, wrData[15:0]);
          FN_TYP: begin
            if (nrm)      typR <= wrData[TYPE_W-1:0];
            else if (msk) typR <= {typR[TYPE_W-1:PORT_PINS],
                                   byteNext(typR[PORT_PINS-1:0], 1'b0, 1'b1, wrData[15:0])};
          end
          default: ;
        endcase
      end
    end

    assign cfgFlat[p*PORT_PINS +: PORT_PINS] = cfgR;
    assign oeFlat [p*PORT_PINS +: PORT_PINS] = oeR;
    assign outFlat[p*PORT_PINS +: PORT_PINS] = outR;
    assign enFlat [p*PORT_PINS +: PORT_PINS] = enR;
    assign staFlat[p*PORT_PINS +: PORT_PINS] = staR;
    assign typFlat[p*TYPE_W +: TYPE_W]       = typR;
  end

  logic [31:0] rdWord;
  always_comb begin
    rdWord = '0;
    unique case (strb.func)
      FN_CFG: rdWord[PORT_PINS-1:0] = cfgFlat[strb.port*PORT_PINS +: PORT_PINS];
      FN_OE:  rdWord[PORT_PINS-1:0] = oeFlat [strb.port*PORT_PINS +: PORT_PINS];
      FN_OUT: rdWord[PORT_PINS-1:0] = outFlat[strb.port*PORT_PINS +: PORT_PINS];
      FN_IN:  rdWord[PORT_PINS-1:0] = padIn  [strb.port*PORT_PINS +: PORT_PINS];
      FN_STA: rdWord[PORT_PINS-1:0] = staFlat[strb.port*PORT_PINS +: PORT_PINS];
      FN_EN:  rdWord[PORT_PINS-1:0] = enFlat [strb.port*PORT_PINS +: PORT_PINS];
      FN_TYP: rdWord[TYPE_W-1:0]    = typFlat[strb.port*TYPE_W +: TYPE_W];
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdWord;
    else                rdData <= '0;
  end

  assign padOut = outFlat;
  assign padOe  = cfgFlat & oeFlat;

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_port_bank_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PORTS        = 4,
  parameter int BANK_SEL     = 0,
  parameter int BANK_STRIDE  = 'h80,
  parameter int UPPER_OFFSET = 'h800,
  localparam int PINS        = PORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  input  logic [PINS-1:0]   statusSet
);

  strobe_t         strb;
  logic [PINS-1:0] staFlat;

  gpio_port_bank_ctrl #(
    .ADDR_W(ADDR_W), .PORTS(PORTS), .BANK_SEL(BANK_SEL),
    .BANK_STRIDE(BANK_STRIDE), .UPPER_OFFSET(UPPER_OFFSET)
  ) u_ctrl (
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .busAddr(busAddr),
    .strb(strb)
  );

  gpio_port_bank_dp #(.PORTS(PORTS)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(busWrData),
    .padIn(padIn),
    .statusSet(statusSet),
    .rdData(busRdData),
    .padOut(padOut),
    .padOe(padOe),
    .staFlat(staFlat)
  );

endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
  import gpio_port_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rstN,
  input strobe_t         strb,
  input logic [7:0]      wrSel,
  input logic [31:0]     busRdData,
  input logic [PINS-1:0] padOut,
  input logic [PINS-1:0] padOe,
  input logic [PINS-1:0] staFlat,
  input logic [PINS-1:0] statusSet
);

  logic [PINS-1:0] maskWide;
  logic            anyWr;
  assign maskWide = {{(PINS-8){1'b0}}, wrSel} << (8 * int'(strb.port));
  assign anyWr    = strb.wrNorm || strb.wrMask || strb.wrClr;

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOut == '0 && padOe == '0 && staFlat == '0 && busRdData == '0));

  assert_mask_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && strb.func == FN_OUT) |=> (((padOut ^ $past(padOut)) & ~$past(maskWide)) == '0));

  assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && strb.func == FN_CLR) |=> (busRdData == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|statusSet) |=> ((staFlat & $past(statusSet)) == $past(statusSet)));

  assert_oe_needs_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(padOe & ~$past(padOe))) |-> $past(anyWr));

endmodule

bind gpio_port_bank gpio_port_bank_chk #(.PINS(PINS)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .strb(strb),
  .wrSel(busWrData[15:8]),
  .busRdData(busRdData),
  .padOut(padOut),
  .padOe(padOe),
  .staFlat(staFlat),
  .statusSet(statusSet)
);

// File: tb/tb_gpio_port_bank.sv
`timescale 1ns/1ps
module tb_gpio_port_bank;

  localparam int UP = 'h800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0, padOut, padOe, statusSet = '0;

  int checks = 0, errors = 0;

  logic [7:0]  mCfg[4], mOe[4], mOut[4], mEn[4], mSta[4];
  logic [23:0] mTyp[4];

  gpio_port_bank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .statusSet(statusSet)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] merge(input logic [7:0] cur, input logic [31:0] d);
    return (cur & ~d[15:8]) | (d[7:0] & d[15:8]);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    logic inN, inM;
    int f, p;
    inN = a < 12'h080;
    inM = a >= 12'(UP) && a < 12'(UP + 'h80);
    f = int'(a[6:4]);
    p = int'(a[3:2]);
    if (!(inN || inM)) return 32'h0;
    case (f)
      0: return {24'h0, mCfg[p]};
      1: return {24'h0, mOe[p]};
      2: return {24'h0, mOut[p]};
      3: return inN ? {24'h0, padIn[p*8 +: 8]} : 32'h0;
      4: return {24'h0, mSta[p]};
      5: return {24'h0, mEn[p]};
      6: return {8'h0, mTyp[p]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d, input logic [31:0] s);
    logic inN, inM;
    int f, p;
    inN = a < 12'h080;
    inM = a >= 12'(UP) && a < 12'(UP + 'h80);
    f = int'(a[6:4]);
    p = int'(a[3:2]);
    if (inN) begin
      case (f)
        0: mCfg[p] = d[7:0];
        1: mOe[p]  = d[7:0];
        2: mOut[p] = d[7:0];
        4: mSta[p] = d[7:0];
        5: mEn[p]  = d[7:0];
        6: mTyp[p] = d[23:0];
        7: mSta[p] = mSta[p] & ~d[7:0];
        default: ;
      endcase
    end else if (inM) begin
      case (f)
        0: mCfg[p] = merge(mCfg[p], d);
        1: mOe[p]  = merge(mOe[p], d);
        2: mOut[p] = merge(mOut[p], d);
        4: mSta[p] = merge(mSta[p], d);
        5: mEn[p]  = merge(mEn[p], d);
        6: mTyp[p][7:0] = merge(mTyp[p][7:0], d);
        default: ;
      endcase
    end
    for (int q = 0; q < 4; q++) mSta[q] = mSta[q] | s[q*8 +: 8];
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d; statusSet = s;
    @(negedge clk);
    busWrEn = 1'b0; statusSet = '0;
    modelWrite(a, d, s);
  endtask

  task automatic busRead(input logic [11:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    exp = expRead(a);
    @(negedge clk);
    busRdEn = 1'b0;
    check(tag, busRdData, exp);
  endtask

  task automatic checkPads(input string tag);
    logic [31:0] eo, ee;
    for (int q = 0; q < 4; q++) begin
      eo[q*8 +: 8] = mOut[q];
      ee[q*8 +: 8] = mCfg[q] & mOe[q];
    end
    check({tag, " padOut"}, padOut, eo);
    check({tag, " padOe"}, padOe, ee);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int q = 0; q < 4; q++) begin
      mCfg[q] = '0; mOe[q] = '0; mOut[q] = '0; mEn[q] = '0; mSta[q] = '0; mTyp[q] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 rdData", busRdData, 32'h0);
    checkPads("R1");
    for (int f = 0; f < 8; f++) busRead(12'(f*16 + 4), "R1 reset read");

    // R2: plain write and read-back
    busWrite(12'h004, 32'h0000_00A5, '0);
    busRead(12'h004, "R2 cfg port1");
    busWrite(12'h05C, 32'h0000_003C, '0);
    busRead(12'h05C, "R2 int enable port3");
    busRead(12'h85C, "R3 alias read returns plain reg");

    // R3: masked drive value
    busWrite(12'h028, 32'h0000_000F, '0);
    busWrite(12'h828, 32'h0000_F0A0, '0);
    busRead(12'h028, "R3 masked out port2");
    checkPads("R3");

    // R4: masked type touches plane 0 only
    busWrite(12'h06C, 32'h0012_3456, '0);
    busWrite(12'h86C, 32'h0000_0FFF, '0);
    busRead(12'h06C, "R4 type planes kept");

    // R5: input read, writes ignored
    padIn = 32'hC3_5A_96_E1;
    busWrite(12'h034, 32'h0000_FFFF, '0);
    busWrite(12'h834, 32'h0000_FFFF, '0);
    busRead(12'h034, "R5 input port1");
    busRead(12'h834, "R5 input alias reads zero");
    checkPads("R5");

    // R6: clear register
    busWrite(12'h400, 32'h0, 32'h0000_FF00);
    busWrite(12'h074, 32'h0000_000F, '0);
    busRead(12'h044, "R6 clear low nibble");
    busWrite(12'h874, 32'h0000_FFFF, '0);
    busRead(12'h044, "R6 clear alias ignored");
    busRead(12'h074, "R6 clear reads zero");

    // R7: set beats clear in the same cycle
    busWrite(12'h074, 32'h0000_00FF, 32'h0000_8100);
    busRead(12'h044, "R7 set wins");

    // R8: pad drive enables
    busWrite(12'h000, 32'h0000_00FF, '0);
    busWrite(12'h010, 32'h0000_000F, '0);
    checkPads("R8 both set");
    busWrite(12'h800, 32'h0000_0300, '0);
    checkPads("R8 cfg cleared");

    // R9: foreign addresses
    busWrite(12'h080, 32'h0000_00FF, '0);
    busWrite(12'h8A0, 32'h0000_FFFF, '0);
    busRead(12'h080, "R9 other bank reads zero");
    busRead(12'h000, "R9 cfg untouched");
    checkPads("R9");

    // Random mix
    for (int i = 0; i < 500; i++) begin
      int op, f, p;
      logic [31:0] d, s;
      op = $urandom_range(0, 5);
      f  = $urandom_range(0, 7);
      p  = $urandom_range(0, 3);
      d  = $urandom;
      s  = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom) : 32'h0;
      padIn = $urandom;
      case (op)
        0: begin busWrite(12'(f*16 + p*4), d, s); checkPads("R2 random plain"); end
        1: begin busWrite(12'(UP + f*16 + p*4), d, s); checkPads("R3 random masked"); end
        2: busRead(12'(f*16 + p*4), "R2 random read");
        3: busRead(12'(UP + f*16 + p*4), "R4 random alias read");
        4: begin busWrite(12'h400, d, s); busRead(12'(64 + p*4), "R7 random set"); end
        default: begin busWrite(12'(12'h100 + $urandom_range(0, 'h6FF)), d, '0); checkPads("R9 random foreign"); end
      endcase
    end
    for (int q = 0; q < 4; q++)
      for (int f = 0; f < 8; f++) busRead(12'(f*16 + q*4), "R2 final sweep");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule